// File: doc/BRIEF.md
# Reset Sequencer with Cause Flags

This block collects four reset requests: a power-on request, an external reset pin, a brown-out request and a watchdog time-out. It combines them into one active-low system reset. That reset stays asserted while any request is present. After the last request goes away, the block holds the reset for a fixed number of clock cycles and then releases it. The external pin is asynchronous and active low, so it is synchronised before use. The watchdog time-out is turned into an internal reset pulse one clock long. The hold count starts when that pulse ends.

The block also keeps a four-bit cause register, with one sticky flag per reset source. Software reads this register and clears it through a byte-wide register port that has separate read and write strobes. Resets from the external pin, the brown-out detector or the watchdog leave the flags in place. A power-on request clears the other three flags. The power-on flag itself can only be cleared by software. After a reset, firmware reads the register, learns what caused the reset, and writes zeros to prepare for the next one.

Top module: `rstc_top`

## Requirements
- R1: `sys_rst_n` is low whenever `arst_n` is low or any reset request is active. The active requests are `por_req`, `bor_req`, the synchronised external pin and the watchdog pulse.
- R2: After the last request goes away, `sys_rst_n` stays low for exactly HOLD_CYCLES cycles (16 by default). A new request during that hold restarts the count from the full value.
- R3: `ext_rst_n` is active low and passes through a two-flop synchroniser. If it is held low for L cycles, `sys_rst_n` is low for exactly L + HOLD_CYCLES sampled cycles.
- R4: A rising edge on `wdt_expire` produces exactly one high cycle on `wdt_rst_pulse`, however long `wdt_expire` stays high. The hold count starts when that pulse falls, so `sys_rst_n` is low for 1 + HOLD_CYCLES cycles.
- R5: The cause register uses this bit map: bit 3 is the watchdog flag, bit 2 the brown-out flag, bit 1 the external flag and bit 0 the power-on flag. Bits 7 to 4 always read as zero, and writes to them have no effect.
- R6: Brown-out, external and watchdog resets each set only their own flag. They clear no other flag.
- R7: A power-on request sets bit 0 and clears bits 3 to 1.
- R8: Writing a zero to a flag bit clears that flag. Writing a one leaves that flag unchanged. The power-on flag is cleared only by a written zero.
- R9: If a set event and a written zero reach the same flag in the same cycle, the flag ends up set.
- R10: While `reg_rd` is high, `reg_rdata` shows the current flags in the same cycle. While `reg_rd` is low, `reg_rdata` reads zero.
- R11: While `arst_n` is low, all flags and the hold counter are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous cold reset, active low, released synchronously |
| por_req | input | 1 | Power-on request, active-high qualified level |
| bor_req | input | 1 | Brown-out request, active-high qualified level |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdt_expire | input | 1 | Watchdog time-out indication, rising edge is used |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| wdt_rst_pulse | output | 1 | One-cycle internal watchdog reset pulse |
| sys_rst_n | output | 1 | System reset, active low |

## Verification
The hardest case to reach from the ports is a written zero that lands on the watchdog flag in the same cycle the flag is set. The pulse appears one cycle after the edge on `wdt_expire`, and the flag is updated one cycle after that. The bench raises `wdt_expire` at a falling clock edge and asserts the write strobe one full cycle later, so that both events meet at the same rising edge. Restarting the hold is reached by starting a brown-out request partway through a power-on hold. The length of the reset window then shows whether the counter reloaded.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int unsigned NUM_CAUSES = 4;
  localparam int unsigned REG_W      = 8;
  // cause bit positions as seen by software
  localparam int unsigned IDX_POR = 0;
  localparam int unsigned IDX_EXT = 1;
  localparam int unsigned IDX_BOR = 2;
  localparam int unsigned IDX_WDT = 3;
  typedef logic [NUM_CAUSES-1:0] cause_vec_t;
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign stage_d[s] = d_i;
      end else begin : g_next
        assign stage_d[s] = stage_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= {STAGES{RST_VAL}};
    else         stage_q <= stage_d;
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/rstc_edge_pulse.sv
module rstc_edge_pulse (
  input  logic clk,
  input  logic arst_n,
  input  logic lvl_i,
  output logic pulse_o
);
  logic lvl_q, pulse_q, pulse_d;

  always_comb begin
    pulse_d = lvl_i & ~lvl_q;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      lvl_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      lvl_q   <= lvl_i;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;

  // R4
  pulse_single_chk: assert property (@(posedge clk) disable iff (!arst_n)
    pulse_q |=> !pulse_q);
  // R4
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(pulse_q) |-> $past(lvl_i));
endmodule

// File: rtl/rstc_hold.sv
module rstc_hold #(
  parameter int unsigned HOLD_CYCLES = 16
) (
  input  logic clk,
  input  logic arst_n,
  input  logic src_i,
  output logic busy_o
);
  localparam int unsigned CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HOLD_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (src_i) begin
      cnt_en = 1'b1;
      cnt_d  = CNT_LOAD;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy_o = src_i | (cnt_q != '0);

  // R2
  hold_reload_chk: assert property (@(posedge clk) disable iff (!arst_n)
    src_i |=> (cnt_q == CNT_LOAD));
  // R2
  hold_step_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (!src_i && cnt_q != '0) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));
endmodule

// File: rtl/rstc_flags.sv
module rstc_flags
  import rstc_pkg::*;
(
  input  logic       clk,
  input  logic       arst_n,
  input  cause_vec_t set_i,
  input  logic       por_i,
  input  logic       wr_i,
  input  cause_vec_t wdata_i,
  output cause_vec_t flags_o
);
  cause_vec_t flags_q, flags_d, clr, en;

  generate
    for (genvar i = 0; i < NUM_CAUSES; i++) begin : g_bit
      if (i == IDX_POR) begin : g_por
        assign clr[i] = wr_i & ~wdata_i[i];
      end else begin : g_oth
        assign clr[i] = (wr_i & ~wdata_i[i]) | por_i;
      end
      // set dominates clear
      assign flags_d[i] = set_i[i] | (flags_q[i] & ~clr[i]);
      assign en[i]      = set_i[i] | clr[i];

      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)    flags_q[i] <= 1'b0;
        else if (en[i]) flags_q[i] <= flags_d[i];
      end

      // R9
      flag_set_wins_chk: assert property (@(posedge clk) disable iff (!arst_n)
        set_i[i] |=> flags_q[i]);
    end
  endgenerate

  assign flags_o = flags_q;

  // R8
  por_flag_clear_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(flags_q[IDX_POR]) |-> $past(wr_i && !wdata_i[IDX_POR]));
  // R6
  flags_sticky_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (!por_i && !wr_i) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

// File: rtl/rstc_top.sv
module rstc_top
  import rstc_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             por_req,
  input  logic             bor_req,
  input  logic             ext_rst_n,
  input  logic             wdt_expire,
  input  logic             reg_rd,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             wdt_rst_pulse,
  output logic             sys_rst_n
);
  logic       ext_n_s, ext_act, wdt_pulse, any_src, hold_busy;
  cause_vec_t set_vec, flags;

  rstc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ext_sync (
    .clk(clk), .arst_n(arst_n), .d_i(ext_rst_n), .q_o(ext_n_s));

  rstc_edge_pulse u_wdt_pulse (
    .clk(clk), .arst_n(arst_n), .lvl_i(wdt_expire), .pulse_o(wdt_pulse));

  always_comb begin
    ext_act          = ~ext_n_s;
    any_src          = por_req | bor_req | ext_act | wdt_pulse;
    set_vec          = '0;
    set_vec[IDX_POR] = por_req;
    set_vec[IDX_EXT] = ext_act;
    set_vec[IDX_BOR] = bor_req;
    set_vec[IDX_WDT] = wdt_pulse;
  end

  rstc_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk(clk), .arst_n(arst_n), .src_i(any_src), .busy_o(hold_busy));

  rstc_flags u_flags (
    .clk(clk), .arst_n(arst_n), .set_i(set_vec), .por_i(por_req),
    .wr_i(reg_wr), .wdata_i(reg_wdata[NUM_CAUSES-1:0]), .flags_o(flags));

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) reg_rdata[NUM_CAUSES-1:0] = flags;
  end

  assign wdt_rst_pulse = wdt_pulse;
  assign sys_rst_n     = arst_n & ~hold_busy;

  // R1
  rst_on_src_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (por_req || bor_req || wdt_rst_pulse) |-> !sys_rst_n);
  // R7
  por_clears_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (por_req && !bor_req && !wdt_rst_pulse && ext_n_s) |=> (flags == 4'b0001));
endmodule

// File: tb/sim_rstc_top.sv
module sim_rstc_top;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 16;

  logic clk = 1'b0;
  logic arst_n, por_req, bor_req, ext_rst_n, wdt_expire;
  logic reg_rd, reg_wr;
  logic [7:0] reg_wdata, reg_rdata;
  logic wdt_rst_pulse, sys_rst_n;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rstc_top #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(2)) u0 (
    .clk(clk), .arst_n(arst_n), .por_req(por_req), .bor_req(bor_req),
    .ext_rst_n(ext_rst_n), .wdt_expire(wdt_expire), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wdt_rst_pulse(wdt_rst_pulse), .sys_rst_n(sys_rst_n));

  task automatic check(string req, int got, int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic read_flags(output logic [7:0] v);
    reg_rd = 1'b1;
    #1 v = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic write_reg(logic [7:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  // drives sources by sample index k; counts low samples of sys_rst_n and pulses
  task automatic pulse_window(int por_len, int bor_start, int bor_len, int ext_len,
                              int wdt_len, int win, output int low, output int pulses);
    low = 0; pulses = 0;
    for (int k = 0; k < win; k++) begin
      por_req    = (k < por_len);
      bor_req    = (k >= bor_start) && (k < bor_start + bor_len);
      ext_rst_n  = !(k < ext_len);
      wdt_expire = (k < wdt_len);
      #1;
      if (!sys_rst_n) low++;
      if (wdt_rst_pulse) pulses++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset_state();
    logic [7:0] v;
    arst_n = 1'b0; por_req = 1'b1; bor_req = 1'b0; ext_rst_n = 1'b1;
    wdt_expire = 1'b0; reg_rd = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
    repeat (3) @(negedge clk);
    #1 check("R1 rst during arst", sys_rst_n, 0);
    read_flags(v);
    check("R11 flags under arst", v, 8'h00);
    @(negedge clk);
    arst_n = 1'b1;
    repeat (3) @(negedge clk);
    read_flags(v);
    check("R7 por flag set", v, 8'h01);
  endtask

  task automatic t_por_release();
    int low, p;
    logic [7:0] v;
    pulse_window(0, 1000, 0, 0, 0, HOLD + 6, low, p);
    check("R2 hold after por", low, HOLD);
    read_flags(v);
    check("R7 por only", v, 8'h01);
  endtask

  task automatic t_clear();
    logic [7:0] v;
    write_reg(8'h00);
    read_flags(v);
    check("R8 write zero clears", v, 8'h00);
    write_reg(8'hFF);
    read_flags(v);
    check("R8 write one no set", v, 8'h00);
  endtask

  task automatic t_ext();
    int low, p;
    logic [7:0] v;
    pulse_window(0, 1000, 0, 4, 0, 4 + HOLD + 8, low, p);
    check("R3 ext window", low, 4 + HOLD);
    read_flags(v);
    check("R6 ext flag", v, 8'h02);
  endtask

  task automatic t_wdt();
    int low, p;
    logic [7:0] v;
    pulse_window(0, 1000, 0, 0, 5, HOLD + 10, low, p);
    check("R4 single pulse", p, 1);
    check("R4 wdt window", low, 1 + HOLD);
    read_flags(v);
    check("R6 wdt keeps ext", v, 8'h0A);
  endtask

  task automatic t_bor();
    int low, p;
    logic [7:0] v;
    pulse_window(0, 0, 2, 0, 0, HOLD + 6, low, p);
    check("R2 bor window", low, 2 + HOLD);
    read_flags(v);
    check("R6 bor keeps others", v, 8'h0E);
  endtask

  task automatic t_bitmap();
    logic [7:0] v;
    write_reg(8'hFF);
    read_flags(v);
    check("R5 upper bits zero", v, 8'h0E);
    write_reg(8'hF7);
    read_flags(v);
    check("R5 bit3 watchdog", v, 8'h06);
    write_reg(8'hFB);
    read_flags(v);
    check("R5 bit2 brownout", v, 8'h02);
    write_reg(8'hFD);
    read_flags(v);
    check("R5 bit1 external", v, 8'h00);
  endtask

  task automatic t_set_wins();
    logic [7:0] v;
    wdt_expire = 1'b1;
    @(posedge clk); @(negedge clk);
    wdt_expire = 1'b0;
    reg_wr = 1'b1; reg_wdata = 8'h00;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
    read_flags(v);
    check("R9 set beats clear", v, 8'h08);
    repeat (HOLD + 4) @(negedge clk);
    #1 check("R4 released", sys_rst_n, 1);
  endtask

  task automatic t_restart();
    int low, p;
    logic [7:0] v;
    pulse_window(3, 8, 1, 0, 0, 9 + HOLD + 6, low, p);
    check("R2 restart", low, 9 + HOLD);
    read_flags(v);
    check("R7 por cleared wdt", v, 8'h05);
  endtask

  task automatic t_por_clears();
    int low, p;
    logic [7:0] v;
    pulse_window(0, 1000, 0, 2, 0, HOLD + 8, low, p);
    read_flags(v);
    check("R6 ext adds", v, 8'h07);
    pulse_window(2, 1000, 0, 0, 0, HOLD + 6, low, p);
    read_flags(v);
    check("R7 por clears others", v, 8'h01);
    reg_rd = 1'b0;
    #1 check("R10 rdata idle zero", reg_rdata, 8'h00);
  endtask

  task automatic t_arst_clear();
    logic [7:0] v;
    @(negedge clk);
    arst_n = 1'b0;
    #1 check("R1 arst forces reset", sys_rst_n, 0);
    @(negedge clk);
    arst_n = 1'b1;
    @(negedge clk);
    read_flags(v);
    check("R11 flags cleared", v, 8'h00);
    #1 check("R11 counter cleared", sys_rst_n, 1);
  endtask

  initial begin
    t_reset_state();
    t_por_release();
    t_clear();
    t_ext();
    t_wdt();
    t_bor();
    t_bitmap();
    t_set_wins();
    t_restart();
    t_por_clears();
    t_arst_clear();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule